// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits behind the write port of a NOR-style flash command interface. Each bus write cycle is offered as a one-clock strobe with a word address and a data byte. The block steps through the multi-cycle unlock sequences and produces a single-cycle program, sector-erase or chip-erase request, together with the address and data latched from the cycle that completed the sequence. A two-bit mode output tells the rest of the flash controller whether the interface is in read mode, part way through a sequence, or in unlock-bypass mode.

Unlock-bypass mode shortens programming to two writes and recognises only its own program and reset commands. It is entered by command, or forced while the accelerate input is high. While the erase engine reports busy, every write is discarded and the decoder holds its position. A synchronous reset returns the decoder to read mode from any state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After `rst`, `mode` is 0 (read) and no request is raised. Mode codes are 0 = read, 1 = sequence in progress, 2 = unlock-bypass.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any (address, data) pulse `prog_req` for exactly one cycle, in the cycle after the last write. `req_addr` and `req_data` carry that write's values, and `mode` returns to 0.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h at any address pulse `erase_sector_req` for one cycle, with `req_addr` equal to that last address.
- R4: The same five writes, followed by 10h@555h, pulse `erase_chip_req` for one cycle.
- R5: The writes AAh@555h, 55h@2AAh, 20h@555h put `mode` at 2.
- R6: In bypass, A0h at any address followed by any (address, data) pulses `prog_req` with that address and data, and `mode` stays 2.
- R7: In bypass, a write whose data is neither A0h nor 90h has no effect. `mode` stays 2 and no request is raised.
- R8: In bypass, 90h followed by 00h returns `mode` to 0. If the second write is not 00h, the decoder goes back to bypass.
- R9: A write that does not match the next step of a normal sequence returns `mode` to 0 and raises no request.
- R10: While `erase_busy` is high, writes are ignored and the position in a sequence is kept. No request is raised.
- R11: While `accel_hi` is high, `mode` is 2 from the next cycle on, even across a bypass reset.
- R12: `rst` abandons a sequence in progress. Later writes must start again from the first unlock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; commands in bits 7:0 |
| erase_busy | input | 1 | Erase engine is running |
| accel_hi | input | 1 | Accelerate pin at its high level |
| prog_req | output | 1 | Program request pulse |
| erase_sector_req | output | 1 | Sector erase request pulse |
| erase_chip_req | output | 1 | Chip erase request pulse |
| req_addr | output | ADDR_W | Address latched with the request |
| req_data | output | DATA_W | Data latched with the request |
| mode | output | 2 | 0 read, 1 in sequence, 2 bypass |

## Verification
The hardest case to reach is a busy erase that arrives partway through a six-cycle sequence. The decoder must hold its position rather than drop back to read mode. The stimulus issues three cycles of an erase sequence, raises `erase_busy`, writes a command that would otherwise be accepted, and then lowers busy. The remaining cycles must still produce the sector-erase request. Bypass-only ignoring is checked the same way: a complete normal unlock sequence is written in bypass, followed by a bypass program whose request must still appear.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_BYP_IN  = 8'h20;
  localparam logic [7:0] CMD_BYP_RST = 8'h90;
  localparam logic [7:0] CMD_BYP_END = 8'h00;

  localparam int unsigned UNLOCK_A1 = 'h555;
  localparam int unsigned UNLOCK_A2 = 'h2AA;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PROG, S_SETUP, S_E1, S_E2,
    S_BYP, S_BPROG, S_BRST
  } seq_state_e;

  typedef enum logic [1:0] {
    REQ_NONE, REQ_PROG, REQ_SECTOR, REQ_CHIP
  } req_kind_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0, MODE_SEQ = 2'd1, MODE_BYPASS = 2'd2
  } mode_e;

  function automatic logic in_bypass(input seq_state_e s);
    return (s == S_BYP) || (s == S_BPROG) || (s == S_BRST);
  endfunction

endpackage

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              accel_hi,
  output req_kind_e         fire,
  output mode_e             nxt_mode
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLOCK_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLOCK_A2);

  seq_state_e state, nxt;
  logic [7:0] cmd;
  logic       at_a1, at_a2;

  assign cmd   = wr_data[7:0];
  assign at_a1 = (wr_addr == A1);
  assign at_a2 = (wr_addr == A2);

  always_comb begin
    nxt  = state;
    fire = REQ_NONE;
    if (wr_en) begin
      case (state)
        S_READ:  if (at_a1 && cmd == CMD_UNLOCK1) nxt = S_U1;
        S_U1:    nxt = (at_a2 && cmd == CMD_UNLOCK2) ? S_U2 : S_READ;
        S_U2: begin
          nxt = S_READ;
          if (at_a1) begin
            if (cmd == CMD_PROGRAM)     nxt = S_PROG;
            else if (cmd == CMD_SETUP)  nxt = S_SETUP;
            else if (cmd == CMD_BYP_IN) nxt = S_BYP;
          end
        end
        S_PROG: begin
          fire = REQ_PROG;
          nxt  = S_READ;
        end
        S_SETUP: nxt = (at_a1 && cmd == CMD_UNLOCK1) ? S_E1 : S_READ;
        S_E1:    nxt = (at_a2 && cmd == CMD_UNLOCK2) ? S_E2 : S_READ;
        S_E2: begin
          nxt = S_READ;
          if (cmd == CMD_SECTOR)              fire = REQ_SECTOR;
          else if (at_a1 && cmd == CMD_CHIP)  fire = REQ_CHIP;
        end
        S_BYP: begin
          if (cmd == CMD_PROGRAM)      nxt = S_BPROG;
          else if (cmd == CMD_BYP_RST) nxt = S_BRST;
        end
        S_BPROG: begin
          fire = REQ_PROG;
          nxt  = S_BYP;
        end
        S_BRST:  nxt = (cmd == CMD_BYP_END) ? S_READ : S_BYP;
        default: nxt = S_READ;
      endcase
    end
    if (accel_hi && !in_bypass(nxt)) nxt = S_BYP;
    if (erase_busy) begin
      nxt  = state;
      fire = REQ_NONE;
    end
  end

  always_comb begin
    if (nxt == S_READ)      nxt_mode = MODE_READ;
    else if (in_bypass(nxt)) nxt_mode = MODE_BYPASS;
    else                     nxt_mode = MODE_SEQ;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_READ;
    else     state <= nxt;
  end

  // R10: busy freezes the sequence position
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    erase_busy |=> $stable(state));

  // R7: bypass ignores everything but program and reset commands
  assert_byp_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_BYP && wr_en && !erase_busy && cmd != CMD_PROGRAM && cmd != CMD_BYP_RST)
    |=> state == S_BYP);

  // R11: accelerate level forces bypass
  assert_accel_byp_R11: assert property (@(posedge clk) disable iff (rst)
    (accel_hi && !erase_busy) |=> in_bypass(state));

endmodule

// File: rtl/fcd_request_reg.sv
module fcd_request_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  req_kind_e         fire,
  input  mode_e             nxt_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_req,
  output logic              erase_sector_req,
  output logic              erase_chip_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_req         <= 1'b0;
      erase_sector_req <= 1'b0;
      erase_chip_req   <= 1'b0;
      req_addr         <= '0;
      req_data         <= '0;
      mode             <= MODE_READ;
    end else begin
      prog_req         <= (fire == REQ_PROG);
      erase_sector_req <= (fire == REQ_SECTOR);
      erase_chip_req   <= (fire == REQ_CHIP);
      mode             <= nxt_mode;
      if (fire != REQ_NONE) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  // R2: at most one request kind at a time
  assert_one_req_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, erase_sector_req, erase_chip_req}));

  // R2: program request is a single-cycle pulse
  assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);

  // R3: sector erase request is a single-cycle pulse
  assert_sector_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    erase_sector_req |=> !erase_sector_req);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              accel_hi,
  output logic              prog_req,
  output logic              erase_sector_req,
  output logic              erase_chip_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        mode
);

  req_kind_e fire;
  mode_e     nxt_mode;

  fcd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_busy(erase_busy), .accel_hi(accel_hi),
    .fire(fire), .nxt_mode(nxt_mode)
  );

  fcd_request_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .fire(fire), .nxt_mode(nxt_mode),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_req(prog_req), .erase_sector_req(erase_sector_req),
    .erase_chip_req(erase_chip_req), .req_addr(req_addr),
    .req_data(req_data), .mode(mode)
  );

  // R10: no request follows a busy cycle
  assert_busy_no_req_R10: assert property (@(posedge clk) disable iff (rst)
    erase_busy |=> !(prog_req || erase_sector_req || erase_chip_req));

  // R1: mode code never leaves its three defined values
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam int AW = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          erase_busy = 1'b0;
  logic          accel_hi = 1'b0;
  logic          prog_req, erase_sector_req, erase_chip_req;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [1:0]    mode;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          kind;   // 1 prog, 2 sector, 3 chip
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int          req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_busy(erase_busy), .accel_hi(accel_hi),
    .prog_req(prog_req), .erase_sector_req(erase_sector_req),
    .erase_chip_req(erase_chip_req), .req_addr(req_addr),
    .req_data(req_data), .mode(mode)
  );

  // monitor: pops expected requests as pulses appear
  always @(negedge clk) begin
    if (!rst && (prog_req || erase_sector_req || erase_chip_req)) begin
      int k;
      k = prog_req ? 1 : (erase_sector_req ? 2 : 3);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request kind %0d addr %h data %h (expected none)", k, req_addr, req_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (k != e.kind || req_addr != e.addr || req_data != e.data ||
            ((prog_req + erase_sector_req + erase_chip_req) != 1)) begin
          errors++;
          $display("FAIL R%0d request kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                   e.req, k, req_addr, req_data, e.kind, e.addr, e.data);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_req(input int kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int req);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check_mode(input logic [1:0] exp, input string tag);
    checks++;
    if (mode !== exp) begin
      errors++;
      $display("FAIL %s mode %0d expected %0d", tag, mode, exp);
    end
  endtask

  task automatic check_drained(input string tag);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing %0d request(s) expected 0 pending", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (mode !== 2'd0 || prog_req || erase_sector_req || erase_chip_req) begin
      errors++;
      $display("FAIL R1 reset mode %0d reqs %b%b%b expected 0 000", mode,
               prog_req, erase_sector_req, erase_chip_req);
    end
    rst = 1'b0;
    @(negedge clk);
    check_mode(2'd0, "R1 after reset");

    // R2: normal program
    unlock();
    check_mode(2'd1, "R2 mid sequence");
    wr(12'h555, 8'hA0);
    expect_req(1, 12'h123, 8'h5C, 2);
    wr(12'h123, 8'h5C);
    check_mode(2'd0, "R2 back to read");
    check_drained("R2");

    // R3: sector erase
    unlock(); wr(12'h555, 8'h80); unlock();
    expect_req(2, 12'hA40, 8'h30, 3);
    wr(12'hA40, 8'h30);
    check_drained("R3");

    // R4: chip erase
    unlock(); wr(12'h555, 8'h80); unlock();
    expect_req(3, 12'h555, 8'h10, 4);
    wr(12'h555, 8'h10);
    check_drained("R4");

    // R9: mismatches
    wr(12'h554, 8'hAA);
    check_mode(2'd0, "R9 wrong unlock addr");
    unlock(); wr(12'h555, 8'h33);
    check_mode(2'd0, "R9 bad command");
    unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55);
    check_mode(2'd0, "R9 bad second unlock");
    check_drained("R9");

    // R10: busy mid sequence keeps position
    unlock(); wr(12'h555, 8'h80);
    erase_busy = 1'b1;
    wr(12'h555, 8'hAA);
    wr(12'h777, 8'h01);
    erase_busy = 1'b0;
    @(negedge clk);
    check_mode(2'd1, "R10 held during busy");
    unlock();
    expect_req(2, 12'h200, 8'h30, 10);
    wr(12'h200, 8'h30);
    check_drained("R10");

    // R12: reset abandons a sequence
    unlock(); wr(12'h555, 8'h80);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_mode(2'd0, "R12 reset in sequence");
    unlock(); wr(12'h300, 8'h30);
    check_mode(2'd0, "R12 no erase after reset");
    check_drained("R12");

    // R5: bypass entry
    unlock(); wr(12'h555, 8'h20);
    check_mode(2'd2, "R5 bypass entered");

    // R7: ignored writes in bypass
    unlock(); wr(12'h555, 8'h80); wr(12'h400, 8'h30);
    check_mode(2'd2, "R7 bypass kept");
    check_drained("R7 no request");

    // R6: bypass program
    wr(12'h0F0, 8'hA0);
    expect_req(1, 12'h0F1, 8'h3E, 6);
    wr(12'h0F1, 8'h3E);
    check_mode(2'd2, "R6 stays bypass");
    check_drained("R6");

    // R8: bypass reset, bad second cycle then proper exit
    wr(12'h100, 8'h90); wr(12'h000, 8'h01);
    check_mode(2'd2, "R8 bad reset stays bypass");
    wr(12'h100, 8'h90); wr(12'h000, 8'h00);
    check_mode(2'd0, "R8 exit to read");

    // R11: accelerate level
    @(negedge clk); accel_hi = 1'b1;
    @(negedge clk);
    check_mode(2'd2, "R11 accel forces bypass");
    wr(12'h010, 8'hA0);
    expect_req(1, 12'h011, 8'h77, 11);
    wr(12'h011, 8'h77);
    wr(12'h100, 8'h90); wr(12'h000, 8'h00);
    check_mode(2'd2, "R11 reset ignored while accel");
    accel_hi = 1'b0;
    wr(12'h100, 8'h90); wr(12'h000, 8'h00);
    check_mode(2'd0, "R11 exit after accel low");
    check_drained("R11");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule